// File: doc/BRIEF.md
# CSR Access Permission Checker

This block decides, in the same cycle, whether an instruction that names a 12-bit control/status register address may go ahead or must raise an illegal-instruction exception. It holds no state: the decode stage presents the address, the current privilege, whether the instruction writes the register, a handful of configuration straps and the control bits that gate counter and address-translation access. One output bit then says whether the access is allowed.

Legality is the conjunction of four independent verdicts. The first is a field check of the address bits themselves, covering read-only encoding and minimum privilege. The second is a table of registers that exist under the current configuration and privilege. The third is a gate covering the translation trap bit, the two counter-enable masks, the performance-counter hole and the entropy-seed rules. The fourth rejects the reserved privilege code. The register storage lives elsewhere; this block only judges the access.

Top module: `csr_perm_check`

## Requirements
- R1: When address bits [11:10] equal 2'b11 the register is read-only, and any access with `is_write`=1 is refused.
- R2: Address bits [9:8] hold the lowest privilege allowed, and access is refused when `cur_priv` (User=2'b00, Supervisor=2'b01, Machine=2'b11) is unsigned-less than that field.
- R3: The privilege code 2'b10 is reserved, and every access made under it is refused.
- R4: Any address outside the defined set is refused, including the performance-counter range 0xC03 to 0xC1F.
- R5: Registers 0x310, 0x3A1, 0x3A3, 0xB80, 0xB82 and 0xC80 to 0xC82 exist only when `cfg_xlen32`=1.
- R6: Registers 0x100, 0x104 to 0x106, 0x140 to 0x144 and 0x180 exist only when `cfg_has_smode`=1, and only under Supervisor or Machine privilege.
- R7: Machine registers 0xF11 to 0xF14, 0x300, 0x301, 0x304, 0x305, 0x320, 0x340 to 0x344, 0x3A0, 0x3A2, 0x3B0 to 0x3BF, 0xB00, 0xB02 and 0x7A0 exist only under Machine privilege. Registers 0x302 and 0x303 also need `cfg_has_smode`=1, and 0x306 also needs `cfg_has_umode`=1.
- R8: An access to 0x180 under Supervisor privilege is refused while `tvm_bit`=1.
- R9: Under Supervisor privilege, counters 0xC00, 0xC01 and 0xC02 need bit 0, 1 and 2 respectively of `mcnt_en` to be set.
- R10: Under User privilege, the same counters need the matching `mcnt_en` bit. When `cfg_has_smode`=1 they also need the matching `scnt_en` bit.
- R11: Register 0x015 exists in every configuration, but is allowed only when `is_write`=1 under Machine privilege.
- R12: Counters 0xC00 to 0xC02 exist only when `cfg_has_umode`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| csr_addr | input | 12 | Register address named by the instruction |
| cur_priv | input | 2 | Current privilege: 00 User, 01 Supervisor, 11 Machine, 10 reserved |
| is_write | input | 1 | Instruction would modify the register |
| cfg_has_smode | input | 1 | Supervisor privilege is implemented |
| cfg_has_umode | input | 1 | User privilege is implemented |
| cfg_xlen32 | input | 1 | Core runs with 32-bit registers |
| tvm_bit | input | 1 | Trap supervisor access to the translation register |
| mcnt_en | input | 3 | Machine counter-enable mask: bit0 cycle, bit1 time, bit2 instret |
| scnt_en | input | 3 | Supervisor counter-enable mask, same bit order |
| access_ok | output | 1 | 1 when the access is legal, 0 for an illegal instruction |

## Verification
The hardest case to reach is a User-mode counter read whose outcome depends on three things at once: the machine mask bit, the supervisor mask bit, and whether supervisor mode exists. A plain address sweep holds each mask at a single value, so it only ever sees one of these combinations. The stimulus therefore adds a dedicated sweep over the three counter addresses, every privilege and write flag, both supervisor straps and all 64 mask pairs. The broad part of the stimulus walks every one of the 4096 addresses under all privilege and write combinations, once for each of six configuration vectors that flip the straps and the translation trap bit.

// File: rtl/csr_chk_pkg.sv
package csr_chk_pkg;
    localparam int ADDR_W = 12;
    localparam int CNT_W  = 3;

    typedef enum logic [1:0] {
        PRIV_USR = 2'b00,
        PRIV_SUP = 2'b01,
        PRIV_RSV = 2'b10,
        PRIV_MCH = 2'b11
    } priv_e;

    localparam logic [ADDR_W-1:0] ADR_XLATE  = 12'h180;
    localparam logic [ADDR_W-1:0] ADR_ENTROPY = 12'h015;
    localparam logic [ADDR_W-1:0] ADR_CNT_LO = 12'hC00;
    localparam logic [ADDR_W-1:0] ADR_CNT_HI = 12'hC02;
    localparam logic [ADDR_W-1:0] ADR_HPM_LO = 12'hC03;
    localparam logic [ADDR_W-1:0] ADR_HPM_HI = 12'hC1F;
endpackage

// File: rtl/csr_def_decode.sv
module csr_def_decode
    import csr_chk_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  priv_e             priv,
    input  logic              has_s,
    input  logic              has_u,
    input  logic              xlen32,
    output logic              defined
);
    logic in_mch;
    logic in_sup_or_mch;

    assign in_mch        = (priv == PRIV_MCH);
    assign in_sup_or_mch = (priv == PRIV_MCH) || (priv == PRIV_SUP);

    always_comb begin
        defined = 1'b0;
        case (addr) inside
            12'hF11, 12'hF12, 12'hF13, 12'hF14,
            12'h300, 12'h301, 12'h304, 12'h305, 12'h320,
            [12'h340:12'h344],
            12'h3A0, 12'h3A2,
            [12'h3B0:12'h3BF],
            12'hB00, 12'hB02, 12'h7A0:
                defined = in_mch;
            12'h302, 12'h303:
                defined = in_mch && has_s;
            12'h306:
                defined = in_mch && has_u;
            12'h310, 12'h3A1, 12'h3A3, 12'hB80, 12'hB82:
                defined = in_mch && xlen32;
            12'h100, [12'h104:12'h106], [12'h140:12'h144], 12'h180:
                defined = has_s && in_sup_or_mch;
            [12'hC00:12'hC02]:
                defined = has_u;
            [12'hC80:12'hC82]:
                defined = has_u && xlen32;
            12'h015:
                defined = 1'b1;
            default:
                defined = 1'b0;
        endcase
    end
endmodule

// File: rtl/csr_field_check.sv
module csr_field_check
    import csr_chk_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  priv_e             priv,
    input  logic              wr,
    output logic              field_ok
);
    logic [1:0] acc_kind;
    logic [1:0] min_priv;
    logic       ro_hit;
    logic       rank_ok;

    assign acc_kind = addr[11:10];
    assign min_priv = addr[9:8];
    assign ro_hit   = wr && (acc_kind == 2'b11);
    assign rank_ok  = (priv >= min_priv);
    assign field_ok = !ro_hit && rank_ok;
endmodule

// File: rtl/csr_gate_check.sv
module csr_gate_check
    import csr_chk_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  priv_e             priv,
    input  logic              wr,
    input  logic              has_s,
    input  logic              tvm,
    input  logic [CNT_W-1:0]  mcnt,
    input  logic [CNT_W-1:0]  scnt,
    output logic              gate_ok
);
    localparam int IDX_W = $clog2(CNT_W + 1);

    logic [2**IDX_W-1:0] m_ext;
    logic [2**IDX_W-1:0] s_ext;
    logic [IDX_W-1:0]    idx;
    logic                is_cnt;
    logic                cnt_ok;
    logic                xlate_ok;
    logic                hpm_ok;
    logic                seed_ok;

    assign m_ext  = (2**IDX_W)'(mcnt);
    assign s_ext  = (2**IDX_W)'(scnt);
    assign idx    = addr[IDX_W-1:0];
    assign is_cnt = (addr >= ADR_CNT_LO) && (addr <= ADR_CNT_HI);

    always_comb begin
        cnt_ok = 1'b1;
        if (is_cnt) begin
            unique case (priv)
                PRIV_SUP: cnt_ok = m_ext[idx];
                PRIV_USR: cnt_ok = m_ext[idx] && (!has_s || s_ext[idx]);
                default:  cnt_ok = 1'b1;
            endcase
        end
    end

    assign xlate_ok = !((addr == ADR_XLATE) && (priv == PRIV_SUP) && tvm);
    assign hpm_ok   = !((addr >= ADR_HPM_LO) && (addr <= ADR_HPM_HI));
    assign seed_ok  = (addr != ADR_ENTROPY) || (wr && (priv == PRIV_MCH));
    assign gate_ok  = cnt_ok && xlate_ok && hpm_ok && seed_ok;
endmodule

// File: rtl/csr_perm_check.sv
module csr_perm_check
    import csr_chk_pkg::*;
(
    input  logic [11:0] csr_addr,
    input  logic [1:0]  cur_priv,
    input  logic        is_write,
    input  logic        cfg_has_smode,
    input  logic        cfg_has_umode,
    input  logic        cfg_xlen32,
    input  logic        tvm_bit,
    input  logic [2:0]  mcnt_en,
    input  logic [2:0]  scnt_en,
    output logic        access_ok
);
    priv_e priv;
    logic  defined;
    logic  field_ok;
    logic  gate_ok;
    logic  priv_valid;

    assign priv       = priv_e'(cur_priv);
    assign priv_valid = (priv != PRIV_RSV);

    csr_def_decode u_def (
        .addr    (csr_addr),
        .priv    (priv),
        .has_s   (cfg_has_smode),
        .has_u   (cfg_has_umode),
        .xlen32  (cfg_xlen32),
        .defined (defined)
    );

    csr_field_check u_field (
        .addr     (csr_addr),
        .priv     (priv),
        .wr       (is_write),
        .field_ok (field_ok)
    );

    csr_gate_check u_gate (
        .addr    (csr_addr),
        .priv    (priv),
        .wr      (is_write),
        .has_s   (cfg_has_smode),
        .tvm     (tvm_bit),
        .mcnt    (mcnt_en),
        .scnt    (scnt_en),
        .gate_ok (gate_ok)
    );

    assign access_ok = priv_valid && defined && field_ok && gate_ok;

    // Final verdict checked against port-level rules, one per requirement.
    always_comb begin
        if (is_write && csr_addr[11:10] == 2'b11)
            p_ro_write_r1: assert (!access_ok) else $error("read-only write allowed");
        if (cur_priv < csr_addr[9:8])
            p_low_rank_r2: assert (!access_ok) else $error("privilege below field allowed");
        if (cur_priv == 2'b10)
            p_rsv_priv_r3: assert (!access_ok) else $error("reserved privilege allowed");
        if (csr_addr >= 12'hC03 && csr_addr <= 12'hC1F)
            p_hpm_hole_r4: assert (!access_ok) else $error("perf counter allowed");
        if (csr_addr == 12'h180 && cur_priv == 2'b01 && tvm_bit)
            p_xlate_trap_r8: assert (!access_ok) else $error("trapped translation access allowed");
        if (csr_addr == 12'h015 && (!is_write || cur_priv != 2'b11))
            p_seed_rule_r11: assert (!access_ok) else $error("seed access allowed");
        if (access_ok)
            p_ok_needs_def_r4: assert (defined && field_ok) else $error("verdict without decode");
    end
endmodule

// File: tb/csr_perm_check_tb.sv
module csr_perm_check_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;
    localparam int MAX_FAIL_PRINT = 40;

    logic        clk = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [1:0]  cur_priv = '0;
    logic        is_write = 1'b0;
    logic        cfg_has_smode = 1'b0;
    logic        cfg_has_umode = 1'b0;
    logic        cfg_xlen32 = 1'b0;
    logic        tvm_bit = 1'b0;
    logic [2:0]  mcnt_en = '0;
    logic [2:0]  scnt_en = '0;
    logic        access_ok;

    int  n_run  = 0;
    int  n_fail = 0;
    int  cycles = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csr_perm_check dut_i (
        .csr_addr      (csr_addr),
        .cur_priv      (cur_priv),
        .is_write      (is_write),
        .cfg_has_smode (cfg_has_smode),
        .cfg_has_umode (cfg_has_umode),
        .cfg_xlen32    (cfg_xlen32),
        .tvm_bit       (tvm_bit),
        .mcnt_en       (mcnt_en),
        .scnt_en       (scnt_en),
        .access_ok     (access_ok)
    );

    // Independent model built from the requirement text; tag names the deciding rule.
    function automatic bit model(input int a, input int p, input bit w,
                                 input bit hs, input bit hu, input bit x32,
                                 input bit tv, input int mc, input int sc,
                                 output string tag);
        bit m  = (p == 3);
        bit sm = (p == 3) || (p == 1);
        bit def;
        int k;
        if (p == 2) begin tag = "R3"; return 0; end
        if (w && (a / 1024) == 3) begin tag = "R1"; return 0; end
        if (p < ((a / 256) % 4)) begin tag = "R2"; return 0; end
        tag = "R4"; def = 0;
        if ((a >= 'hF11 && a <= 'hF14) || a == 'h300 || a == 'h301 || a == 'h304 ||
            a == 'h305 || a == 'h320 || (a >= 'h340 && a <= 'h344) || a == 'h3A0 ||
            a == 'h3A2 || (a >= 'h3B0 && a <= 'h3BF) || a == 'hB00 || a == 'hB02 ||
            a == 'h7A0) begin tag = "R7"; def = m; end
        else if (a == 'h302 || a == 'h303) begin tag = "R7"; def = m && hs; end
        else if (a == 'h306) begin tag = "R7"; def = m && hu; end
        else if (a == 'h310 || a == 'h3A1 || a == 'h3A3 || a == 'hB80 || a == 'hB82)
            begin tag = "R5"; def = m && x32; end
        else if (a == 'h100 || (a >= 'h104 && a <= 'h106) || (a >= 'h140 && a <= 'h144) || a == 'h180)
            begin tag = "R6"; def = hs && sm; end
        else if (a >= 'hC00 && a <= 'hC02) begin tag = "R12"; def = hu; end
        else if (a >= 'hC80 && a <= 'hC82) begin tag = "R5"; def = hu && x32; end
        else if (a == 'h015) begin tag = "R11"; def = 1; end
        if (!def) return 0;
        if (a == 'h180 && p == 1 && tv) begin tag = "R8"; return 0; end
        if (a >= 'hC00 && a <= 'hC02) begin
            k = a - 'hC00;
            if (p == 1) begin tag = "R9"; return ((mc >> k) & 1) == 1; end
            if (p == 0) begin
                tag = "R10";
                return (((mc >> k) & 1) == 1) && (!hs || (((sc >> k) & 1) == 1));
            end
        end
        if (a == 'h015) begin tag = "R11"; return w && m; end
        return 1;
    endfunction

    task automatic check_one(input int a, input int p, input bit w);
        string tag;
        bit exp;
        csr_addr = a[11:0];
        cur_priv = p[1:0];
        is_write = w;
        #1;
        exp = model(a, p, w, cfg_has_smode, cfg_has_umode, cfg_xlen32, tvm_bit,
                    int'(mcnt_en), int'(scnt_en), tag);
        n_run++;
        if (access_ok !== exp) begin
            n_fail++;
            if (n_fail <= MAX_FAIL_PRINT)
                $display("FAIL %s addr=%03h priv=%0d wr=%0b s=%0b u=%0b x32=%0b tvm=%0b m=%0d s=%0d : got %0b expected %0b",
                         tag, a, p, w, cfg_has_smode, cfg_has_umode, cfg_xlen32,
                         tvm_bit, mcnt_en, scnt_en, access_ok, exp);
        end
    endtask

    task automatic set_cfg(input bit hs, input bit hu, input bit x32, input bit tv,
                           input int mc, input int sc);
        cfg_has_smode = hs;
        cfg_has_umode = hu;
        cfg_xlen32    = x32;
        tvm_bit       = tv;
        mcnt_en       = mc[2:0];
        scnt_en       = sc[2:0];
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WATCHDOG_CYCLES && !done) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected under %0d", cycles, WATCHDOG_CYCLES);
            finish_run();
        end
    end

    initial begin
        // Idle inputs: address 0 is undefined, so the verdict must be illegal (R4).
        #1;
        n_run++;
        if (access_ok !== 1'b0) begin
            n_fail++;
            $display("FAIL R4 idle inputs: got %0b expected 0", access_ok);
        end

        // Full address sweep for six configuration vectors (R1..R12).
        for (int c = 0; c < 6 && n_fail < MAX_FAIL_PRINT; c++) begin
            case (c)
                0: set_cfg(1, 1, 1, 1, 7, 7);
                1: set_cfg(1, 1, 0, 0, 7, 0);
                2: set_cfg(0, 1, 1, 0, 5, 0);
                3: set_cfg(0, 0, 0, 1, 0, 7);
                4: set_cfg(1, 1, 1, 0, 2, 5);
                default: set_cfg(1, 0, 0, 1, 7, 7);
            endcase
            for (int a = 0; a < 4096; a++)
                for (int p = 0; p < 4; p++)
                    for (int w = 0; w < 2; w++)
                        check_one(a, p, w[0]);
        end

        // Counter gating: every mask pair, both supervisor straps (R9, R10, R12).
        for (int hs = 0; hs < 2; hs++)
            for (int mc = 0; mc < 8; mc++)
                for (int sc = 0; sc < 8; sc++) begin
                    set_cfg(hs[0], 1, 0, 0, mc, sc);
                    for (int a = 'hC00; a <= 'hC02; a++)
                        for (int p = 0; p < 4; p++)
                            for (int w = 0; w < 2; w++)
                                check_one(a, p, w[0]);
                end

        // Translation trap toggled alone on 0x180 (R8, R6).
        for (int tv = 0; tv < 2; tv++) begin
            set_cfg(1, 1, 0, tv[0], 0, 0);
            for (int p = 0; p < 4; p++)
                for (int w = 0; w < 2; w++)
                    check_one('h180, p, w[0]);
        end

        finish_run();
    end
endmodule